// File: doc/BRIEF.md
# Level and Message Interrupt Source Bank

This block holds a bank of interrupt sources and decides when each one should be offered to a presentation controller. Each source is fixed at build time as either level-sensitive or message-style. Each has a target server number, a priority and a saved priority that can be rewritten through a configuration port. Source numbers seen outside the block are a base offset plus the local index.

Level-sensitive sources follow their input level. Such a source is offered once per assertion, until a reject or an end-of-interrupt clears its delivered state. Message-style sources treat every high input cycle as one event. An event on a masked message source is remembered rather than dropped. A rejected message source is re-offered by the next resend scan.

A priority of 0xFF masks a source. The presentation side can send back a reject or an end-of-interrupt, each tagged with a global source number. It can also request a resend scan, which walks the sources one per cycle. At most one offer leaves per cycle, and the lowest pending index goes first.

Top module: `isc_bank`

## Requirements
- R1: After reset no offer is presented, the resend scan is idle, and every priority reads as masked (0xFF), so an input event causes no offer until the source is configured.
- R2: No offer is ever presented for a source whose priority is 0xFF, and an offered priority is never 0xFF.
- R3: A message source (LSI_MAP bit = 0) with an unmasked priority presents an offer in the cycle after its input is high. The offer carries number BASE+index and the source's configured server and priority.
- R4: A message event on a masked source is remembered as masked-pending. A later configuration write with an unmasked priority clears it and offers. A write that keeps the priority at 0xFF, or a write to a source with nothing pending, makes no offer.
- R5: A level source (LSI_MAP bit = 1) tracks its input level. When its input rises while unmasked, it offers once and marks itself sent. It does not offer again while sent, whether the input stays high or falls and rises again.
- R6: A reject for a message source marks it rejected, and the next resend scan re-offers it once. A reject for a level source clears its sent mark, so a resend scan re-offers it if the input is still high.
- R7: An end-of-interrupt clears the sent mark of a level source without offering at once. It has no effect on a message source, so a later resend scan offers nothing for it.
- R8: A configuration write to a level source re-evaluates it. An asserted, unsent source that the write unmasks is offered in the next cycle.
- R9: Reject and end-of-interrupt numbers outside BASE to BASE+NSRC-1 are ignored.
- R10: When several offers are due together, the lowest index is presented first, and the rest follow one per cycle in rising index order.
- R11: A resend request starts a scan that visits one source per cycle and keeps the busy output high for exactly NSRC cycles. A request made while busy neither restarts nor extends the scan.
- R12: Writing priority 0xFF to a source whose offer is still waiting withdraws that offer. A message source keeps the event as masked-pending and offers when it is unmasked again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Per-source input: level for level sources, event strobe for message sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index of the source being configured |
| cfg_server | input | SRV_W | New target server |
| cfg_prio | input | 8 | New priority (0xFF masks) |
| cfg_saved | input | 8 | New saved priority |
| rej_valid | input | 1 | Reject strobe |
| rej_num | input | NUM_W | Global number of the rejected source |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number of the completed source |
| resend_req | input | 1 | Start a resend scan |
| resend_busy | output | 1 | Resend scan in progress |
| offer_valid | output | 1 | An offer is presented this cycle |
| offer_num | output | NUM_W | Global number of the offered source |
| offer_server | output | SRV_W | Target server of the offer |
| offer_prio | output | 8 | Priority of the offer |

## Verification
The bench configures every message source and offers each one. It fires four events in one cycle to check that offers drain one per cycle in index order; a picker that lost or reordered events would drop or swap numbers. It also drives reject and end-of-interrupt numbers just below and just above the valid range. A design that truncated the local index would hit source 0 or source 5 and produce a stray offer on the next resend. Masking a source while its offer waits must leave no offer and must keep the event for later. Holding and re-raising a level input after it was sent must give no second offer.

// File: rtl/isc_pkg.sv
`timescale 1ns/1ps
package isc_pkg;
    typedef logic [7:0] prio_t;
    localparam prio_t PRIO_OFF = 8'hFF;

    typedef struct packed {
        logic asserted;
        logic sent;
        logic rejected;
        logic mpend;
        logic req;
    } src_flags_t;
endpackage

// File: rtl/isc_source.sv
`timescale 1ns/1ps
module isc_source
    import isc_pkg::*;
#(
    parameter bit IS_LSI = 1'b0,
    parameter int SRV_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_i,
    input  logic             rej_i,
    input  logic             eoi_i,
    input  logic             cfg_we_i,
    input  logic [SRV_W-1:0] cfg_server_i,
    input  prio_t            cfg_prio_i,
    input  prio_t            cfg_saved_i,
    input  logic             scan_i,
    input  logic             grant_i,
    output logic             req_o,
    output logic [SRV_W-1:0] server_o,
    output prio_t            prio_o
);
    typedef struct packed {
        logic [SRV_W-1:0] server;
        prio_t            prio;
        prio_t            saved;
        src_flags_t       f;
    } src_state_t;

    src_state_t d, q;

    always_comb begin
        d = q;
        d.f.req = q.f.req & ~grant_i;
        if (rej_i) begin
            if (IS_LSI) d.f.sent = 1'b0;
            else        d.f.rejected = 1'b1;
        end
        if (eoi_i && IS_LSI) d.f.sent = 1'b0;
        if (cfg_we_i) begin
            d.server = cfg_server_i;
            d.prio   = cfg_prio_i;
            d.saved  = cfg_saved_i;
            if (cfg_prio_i == PRIO_OFF && d.f.req) begin
                d.f.req = 1'b0;
                if (IS_LSI) d.f.sent  = 1'b0;
                else        d.f.mpend = 1'b1;
            end
        end
        if (IS_LSI) begin
            d.f.asserted = lvl_i;
            if ((cfg_we_i || scan_i || (lvl_i != q.f.asserted)) &&
                d.prio != PRIO_OFF && d.f.asserted && !d.f.sent) begin
                d.f.sent = 1'b1;
                d.f.req  = 1'b1;
            end
        end else begin
            if (lvl_i) begin
                if (d.prio == PRIO_OFF) d.f.mpend = 1'b1;
                else                    d.f.req   = 1'b1;
            end
            if (cfg_we_i && d.f.mpend && d.prio != PRIO_OFF) begin
                d.f.mpend = 1'b0;
                d.f.req   = 1'b1;
            end
            if (scan_i && d.f.rejected) begin
                d.f.rejected = 1'b0;
                if (d.prio != PRIO_OFF) d.f.req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.server <= '0;
            q.prio   <= PRIO_OFF;
            q.saved  <= PRIO_OFF;
            q.f      <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_o    = q.f.req;
    assign server_o = q.server;
    assign prio_o   = q.prio;
endmodule

// File: rtl/isc_pick.sv
`timescale 1ns/1ps
module isc_pick #(
    parameter int NSRC  = 8,
    parameter int IDX_W = 3
) (
    input  logic [NSRC-1:0]  req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        valid_o = |req_i;
        idx_o   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/isc_scan.sv
`timescale 1ns/1ps
module isc_scan #(
    parameter int NSRC  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic [IDX_W-1:0] ptr_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NSRC - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] ptr;
    } scan_t;

    scan_t d, q;

    always_comb begin
        d = q;
        if (q.busy) begin
            if (q.ptr == LAST) d.busy = 1'b0;
            else               d.ptr  = q.ptr + 1'b1;
        end else if (start_i) begin
            d.busy = 1'b1;
            d.ptr  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.busy;
    assign ptr_o  = q.ptr;
endmodule

// File: rtl/isc_bank.sv
`timescale 1ns/1ps
module isc_bank
    import isc_pkg::*;
#(
    parameter int              NSRC    = 8,
    parameter int              BASE    = 'h1000,
    parameter int              NUM_W   = 16,
    parameter int              SRV_W   = 4,
    parameter logic [NSRC-1:0] LSI_MAP = 8'hF0,
    localparam int             IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_in,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [SRV_W-1:0] cfg_server,
    input  logic [7:0]       cfg_prio,
    input  logic [7:0]       cfg_saved,
    input  logic             rej_valid,
    input  logic [NUM_W-1:0] rej_num,
    input  logic             eoi_valid,
    input  logic [NUM_W-1:0] eoi_num,
    input  logic             resend_req,
    output logic             resend_busy,
    output logic             offer_valid,
    output logic [NUM_W-1:0] offer_num,
    output logic [SRV_W-1:0] offer_server,
    output logic [7:0]       offer_prio
);
    localparam logic [NUM_W-1:0] BASE_N = NUM_W'(BASE);
    localparam logic [NUM_W-1:0] NSRC_N = NUM_W'(NSRC);

    logic [NUM_W-1:0] rej_rel, eoi_rel;
    logic             rej_in, eoi_in;
    logic [IDX_W-1:0] pick_idx, scan_ptr;
    logic [NSRC-1:0]  req_vec;
    logic [SRV_W-1:0] srv_arr  [NSRC];
    prio_t            prio_arr [NSRC];

    assign rej_rel = rej_num - BASE_N;
    assign eoi_rel = eoi_num - BASE_N;
    assign rej_in  = rej_valid && (rej_num >= BASE_N) && (rej_rel < NSRC_N);
    assign eoi_in  = eoi_valid && (eoi_num >= BASE_N) && (eoi_rel < NSRC_N);

    isc_scan #(.NSRC(NSRC), .IDX_W(IDX_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .start_i(resend_req),
        .busy_o(resend_busy), .ptr_o(scan_ptr)
    );

    isc_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
        .req_i(req_vec), .valid_o(offer_valid), .idx_o(pick_idx)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam logic [IDX_W-1:0] ME = IDX_W'(i);
        isc_source #(.IS_LSI(LSI_MAP[i]), .SRV_W(SRV_W)) u_src (
            .clk(clk), .rst_n(rst_n),
            .lvl_i(src_in[i]),
            .rej_i(rej_in && rej_rel[IDX_W-1:0] == ME),
            .eoi_i(eoi_in && eoi_rel[IDX_W-1:0] == ME),
            .cfg_we_i(cfg_we && cfg_idx == ME),
            .cfg_server_i(cfg_server),
            .cfg_prio_i(cfg_prio),
            .cfg_saved_i(cfg_saved),
            .scan_i(resend_busy && scan_ptr == ME),
            .grant_i(offer_valid && pick_idx == ME),
            .req_o(req_vec[i]),
            .server_o(srv_arr[i]),
            .prio_o(prio_arr[i])
        );
    end

    assign offer_num    = BASE_N + NUM_W'(pick_idx);
    assign offer_server = srv_arr[pick_idx];
    assign offer_prio   = prio_arr[pick_idx];
endmodule

// File: rtl/isc_bank_chk.sv
`timescale 1ns/1ps
module isc_bank_chk #(
    parameter int NSRC  = 8,
    parameter int BASE  = 'h1000,
    parameter int NUM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             resend_req,
    input logic             resend_busy,
    input logic             offer_valid,
    input logic [NUM_W-1:0] offer_num,
    input logic [7:0]       offer_prio
);
    localparam int CW = $clog2(NSRC + 1) + 1;
    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)           busy_cnt <= '0;
        else if (resend_busy) busy_cnt <= busy_cnt + 1'b1;
        else                  busy_cnt <= '0;
    end

    assert_masked_never_offered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> offer_prio != 8'hFF);

    assert_offer_num_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> (offer_num >= NUM_W'(BASE)) && (offer_num < NUM_W'(BASE + NSRC)));

    assert_scan_starts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (resend_req && !resend_busy) |=> resend_busy);

    assert_scan_length_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(resend_busy) |-> busy_cnt == CW'(NSRC));

    always_ff @(posedge clk) begin
        if (rst_n && $past(!rst_n)) begin
            assert_reset_idle_R1: assert (!resend_busy && !offer_valid);
        end
    end
endmodule

bind isc_bank isc_bank_chk #(.NSRC(NSRC), .BASE(BASE), .NUM_W(NUM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .resend_req(resend_req), .resend_busy(resend_busy),
    .offer_valid(offer_valid), .offer_num(offer_num), .offer_prio(offer_prio)
);

// File: tb/isc_bank_test.sv
`timescale 1ns/1ps
module isc_bank_test;
    localparam int NSRC = 8;
    localparam int BASE = 'h1000;
    localparam int NUM_W = 16;
    localparam int SRV_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0] src_in = '0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [SRV_W-1:0] cfg_server = '0;
    logic [7:0] cfg_prio = '0, cfg_saved = '0;
    logic rej_valid = 1'b0, eoi_valid = 1'b0, resend_req = 1'b0;
    logic [NUM_W-1:0] rej_num = '0, eoi_num = '0;
    logic resend_busy, offer_valid;
    logic [NUM_W-1:0] offer_num;
    logic [SRV_W-1:0] offer_server;
    logic [7:0] offer_prio;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int exp_srv [NSRC];
    int exp_prio [NSRC];

    always #2.5 clk = ~clk;

    isc_bank #(.NSRC(NSRC), .BASE(BASE), .NUM_W(NUM_W), .SRV_W(SRV_W), .LSI_MAP(8'hF0)) uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_server(cfg_server), .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
        .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
        .resend_req(resend_req), .resend_busy(resend_busy), .offer_valid(offer_valid),
        .offer_num(offer_num), .offer_server(offer_server), .offer_prio(offer_prio)
    );

    task automatic tick(); @(negedge clk); endtask

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_offer(int i, string tag);
        check({tag, " valid"}, int'(offer_valid), 1);
        check({tag, " num"}, int'(offer_num), BASE + i);
        check({tag, " srv/prio"}, int'({offer_server, offer_prio}), (exp_srv[i] << 8) | exp_prio[i]);
    endtask

    task automatic expect_none(string tag);
        check({tag, " no offer"}, int'(offer_valid), 0);
    endtask

    task automatic cfg(int i, int srv, int pr);
        cfg_we = 1; cfg_idx = 3'(i); cfg_server = SRV_W'(srv);
        cfg_prio = 8'(pr); cfg_saved = 8'(pr);
        exp_srv[i] = srv; exp_prio[i] = pr;
        tick();
        cfg_we = 0;
    endtask

    task automatic pulse(logic [NSRC-1:0] m);
        src_in = src_in | m;
        tick();
        src_in = src_in & ~m;
    endtask

    task automatic reject(int num);
        rej_valid = 1; rej_num = NUM_W'(num); tick(); rej_valid = 0;
    endtask

    task automatic eoi(int num);
        eoi_valid = 1; eoi_num = NUM_W'(num); tick(); eoi_valid = 0;
    endtask

    task automatic resend(output logic [NSRC-1:0] seen);
        resend_req = 1; tick(); resend_req = 0;
        seen = '0;
        repeat (NSRC + 3) begin
            if (offer_valid) seen[offer_num - NUM_W'(BASE)] = 1'b1;
            tick();
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [NSRC-1:0] seen;
        int cnt;
        for (int i = 0; i < NSRC; i++) begin exp_srv[i] = 0; exp_prio[i] = 'hFF; end
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 busy", int'(resend_busy), 0);
        expect_none("R1 reset");
        pulse(8'h01);
        expect_none("R1 masked at reset");
        // R4 masked-pending released by config
        cfg(0, 3, 5);
        expect_offer(0, "R4 unmask releases");
        tick();
        expect_none("R4 drained");
        cfg(0, 3, 5);
        expect_none("R4 no repeat");
        // R3 sweep over message sources
        for (int i = 0; i < 4; i++) begin
            cfg(i, i + 1, i * 16 + 2);
            expect_none("R4 cfg nothing pending");
            pulse(NSRC'(1) << i);
            expect_offer(i, "R3 event");
            tick();
            expect_none("R3 single");
        end
        // R4 masked stays masked
        cfg(1, 6, 'hFF);
        pulse(8'h02);
        expect_none("R2 masked event");
        cfg(1, 6, 'hFF);
        expect_none("R4 still masked");
        cfg(1, 6, 7);
        expect_offer(1, "R4 unmask");
        tick();
        // R6 message reject
        reject(BASE + 2);
        resend(seen);
        check("R6 msi resend", int'(seen), 'h04);
        resend(seen);
        check("R6 msi once", int'(seen), 0);
        // R7 eoi on message source
        eoi(BASE + 3);
        resend(seen);
        check("R7 msi eoi", int'(seen), 0);
        // R5 level source
        cfg(4, 2, 9);
        expect_none("R5 low level");
        src_in[4] = 1; tick();
        expect_offer(4, "R5 rise");
        for (int k = 0; k < 3; k++) begin tick(); expect_none("R5 held"); end
        src_in[4] = 0; tick(); expect_none("R5 fall");
        src_in[4] = 1; tick(); expect_none("R5 reraise sent");
        // R7 eoi on level source
        eoi(BASE + 4);
        expect_none("R7 eoi no immediate");
        resend(seen);
        check("R7 lsi resend", int'(seen), 'h10);
        // R6 level reject
        reject(BASE + 4);
        resend(seen);
        check("R6 lsi resend", int'(seen), 'h10);
        src_in[4] = 0; tick();
        eoi(BASE + 4);
        resend(seen);
        check("R6 lsi deasserted", int'(seen), 0);
        // R8 level config re-evaluation
        src_in[5] = 1; tick();
        expect_none("R2 lsi masked");
        cfg(5, 1, 3);
        expect_offer(5, "R8 cfg unmask");
        tick();
        // R9 out-of-range numbers
        reject(BASE + NSRC);
        reject(BASE - 1);
        eoi(BASE - 3);
        eoi(BASE + NSRC + 5);
        resend(seen);
        check("R9 out of range", int'(seen), 0);
        // R10 simultaneous events
        pulse(8'h0F);
        for (int i = 0; i < 4; i++) begin
            expect_offer(i, "R10 order");
            tick();
        end
        expect_none("R10 drained");
        // R12 withdraw waiting offer
        pulse(8'h0C);
        expect_offer(2, "R12 first");
        cfg(3, 4, 'hFF);
        expect_none("R12 withdrawn");
        cfg(3, 4, 4);
        expect_offer(3, "R12 kept pending");
        tick();
        // R11 scan length and re-request
        resend_req = 1; tick();
        cnt = 0;
        for (int k = 0; k < 3 * NSRC; k++) begin
            if (resend_busy) cnt++;
            if (k == 2) resend_req = 0;
            tick();
        end
        check("R11 busy cycles", cnt, NSRC);
        done = 1;
        finish_run();
    end
endmodule